// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block is the system-control corner of a small in-order processor. It keeps five architectural registers: the saved exception PC, the saved error PC, a cause word, a status word and a captured faulting address. When the pipeline reports a synchronous fault, or when an enabled interrupt is pending, the block records why and where the fault happened. It switches to kernel mode with interrupts masked and issues a one-cycle redirect to the handler entry address. A return request undoes the mode change and redirects to the saved PC.

Reset requests and non-maskable interrupts use a separate error level with its own saved PC. The entry address depends on the kind of event, on a boot-vector bit in status and on a dedicated-interrupt-vector bit in cause. When several requests arrive in the same cycle, one fixed priority decides which is taken. A single write port lets the pipeline load the status word or the interrupt-vector bit.

Top module: `exc_ctl`

Status layout: bits [5:0] hold the mode stack {user2, ie2, user1, ie1, user0, ie0}, where user0 = 1 means user mode and ie0 = 1 means interrupts enabled. Bit 6 is the exception level, bit 7 is the error level and bit 8 is the boot-vector bit. All other bits read 0.

Cause layout: bits [6:2] hold the 5-bit code, bits [15:10] the pending lines, bit 23 the interrupt-vector mode, bits [29:28] the coprocessor number and bit 31 the delay-slot flag.

Exception codes: 0 interrupt, 1 TLB modify, 2 TLB miss on load or fetch, 3 TLB miss on store, 4 address error on load or fetch, 5 address error on store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 floating-point, 23 watch.

## Requirements
- R1: While rstN is low and after it rises, status reads 0x100 (boot bit set), the other registers read 0 and redirectValid is 0.
- R2: A synchronous exception writes its code to cause[6:2] and stores the faulting PC. It pushes the mode stack two places left, which gives kernel mode with ie0 = 0, and sets status bit 6. One cycle later it raises redirectValid.
- R3: When excInSlot is 1 on entry, cause bit 31 is set and the saved PC is excPc − 4. When excInSlot is 0, bit 31 is cleared and the saved PC is excPc.
- R4: Codes 1 to 5 load excAddr into the fault-address register. Every other code, including bus errors 6 and 7, leaves that register unchanged.
- R5: Code 11 writes excCop into cause[29:28]. Other codes leave that field unchanged.
- R6: The handler base is 0xBFC00200 when status bit 8 is 1 and 0x80000000 otherwise. Codes 2 and 3 redirect to base + 0x000, and all other synchronous codes redirect to base + 0x180.
- R7: An interrupt is taken only when some irqLines bit is 1, ie0 is 1 and status bits 6 and 7 are both 0. It then records code 0 and redirects to base + 0x200 when cause bit 23 is 1, or base + 0x180 otherwise.
- R8: cause[15:10] shows irqLines as sampled at the previous clock edge, whether or not the interrupt is taken.
- R9: A reset request or NMI stores excPc in the error PC, pushes the mode stack, sets status bit 7 and redirects to 0xBFC00000. A reset request also sets status bit 8. Neither one changes cause or the exception PC.
- R10: A return pops the mode stack, giving {user2, ie2, user2, ie2, user1, ie1}. If status bit 7 is set, the return clears bit 7 and redirects to the error PC. Otherwise it clears bit 6 and redirects to the exception PC.
- R11: Same-cycle priority is reset request, then NMI, then synchronous exception, then interrupt, then return, then register write. Only the winner has any effect.
- R12: With ctlSel = 0 a write loads status bits [8:0] from ctlWdata. With ctlSel = 1 a write changes only cause bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetReq | input | 1 | Reset-type entry request (error level) |
| nmiReq | input | 1 | Non-maskable interrupt request (error level) |
| excValid | input | 1 | Synchronous exception request from the pipeline |
| excCode | input | 5 | Exception code of the request |
| excPc | input | 32 | PC of the faulting or interrupted instruction |
| excInSlot | input | 1 | The instruction sits in a branch delay slot |
| excAddr | input | 32 | Faulting virtual address |
| excCop | input | COP_W | Coprocessor number for code 11 |
| irqLines | input | IRQ_W | Level interrupt lines |
| retReq | input | 1 | Return-from-exception request |
| ctlWe | input | 1 | Register write strobe |
| ctlSel | input | 1 | Write target: 0 status, 1 cause |
| ctlWdata | input | 32 | Write data |
| redirectValid | output | 1 | One-cycle redirect strobe |
| redirectPc | output | 32 | Redirect target |
| epcOut | output | 32 | Saved exception PC |
| errPcOut | output | 32 | Saved error PC |
| causeOut | output | 32 | Cause word |
| statusOut | output | 32 | Status word |
| badAddrOut | output | 32 | Captured faulting address |

## Verification
The properties assume that request inputs are free of X after reset and that the pipeline holds each request for exactly one cycle. The stack and redirect checks assume that the next cycle's outcome depends only on the requests present in the cycle before. The stimulus drives every input at the falling edge and returns requests to zero one cycle later. It keeps irqLines low during return cycles that the return-pop property examines, so that an interrupt cannot win those cycles. Unused excAddr and excCop values are varied freely, so any wrongful capture shows up at the outputs.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;
  localparam int XLEN = 32;
  localparam int CODE_W = 5;

  // status field positions
  localparam int ST_IE   = 0;
  localparam int ST_EXL  = 6;
  localparam int ST_ERL  = 7;
  localparam int ST_BOOT = 8;
  localparam logic [XLEN-1:0] STATUS_MASK = 32'h0000_01FF;
  localparam logic [XLEN-1:0] STATUS_RST  = 32'h0000_0100;

  // cause field positions
  localparam int CA_CODE_LO = 2;
  localparam int CA_PEND_LO = 10;
  localparam int CA_IV      = 23;
  localparam int CA_COP_LO  = 28;
  localparam int CA_SLOT    = 31;
  localparam logic [XLEN-1:0] CAUSE_IV_MASK = 32'h0080_0000;

  // exception codes
  localparam logic [CODE_W-1:0] EC_INT      = 5'd0;
  localparam logic [CODE_W-1:0] EC_TLB_MOD  = 5'd1;
  localparam logic [CODE_W-1:0] EC_TLB_LD   = 5'd2;
  localparam logic [CODE_W-1:0] EC_TLB_ST   = 5'd3;
  localparam logic [CODE_W-1:0] EC_ADDR_LD  = 5'd4;
  localparam logic [CODE_W-1:0] EC_ADDR_ST  = 5'd5;
  localparam logic [CODE_W-1:0] EC_IBUS     = 5'd6;
  localparam logic [CODE_W-1:0] EC_DBUS     = 5'd7;
  localparam logic [CODE_W-1:0] EC_SYSCALL  = 5'd8;
  localparam logic [CODE_W-1:0] EC_BREAK    = 5'd9;
  localparam logic [CODE_W-1:0] EC_RSVD     = 5'd10;
  localparam logic [CODE_W-1:0] EC_COP_OFF  = 5'd11;
  localparam logic [CODE_W-1:0] EC_OVF      = 5'd12;
  localparam logic [CODE_W-1:0] EC_TRAP     = 5'd13;
  localparam logic [CODE_W-1:0] EC_FPU      = 5'd15;
  localparam logic [CODE_W-1:0] EC_WATCH    = 5'd23;

  // strobes from control to datapath
  typedef struct packed {
    logic              enter;
    logic              errEntry;
    logic              setBoot;
    logic              leave;
    logic              leaveErr;
    logic              wrStatus;
    logic              wrCause;
    logic              takeBad;
    logic              takeCop;
    logic [CODE_W-1:0] code;
  } strobe_t;
endpackage

// File: rtl/exc_ctl_decide.sv
module exc_ctl_decide
  import exc_ctl_pkg::*;
#(
  parameter int              IRQ_W       = 6,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] BOOT_BASE   = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] NORMAL_BASE = 32'h8000_0000,
  parameter logic [XLEN-1:0] REFILL_OFF  = 32'h0000_0000,
  parameter logic [XLEN-1:0] GENERAL_OFF = 32'h0000_0180,
  parameter logic [XLEN-1:0] IRQ_OFF     = 32'h0000_0200
) (
  input  logic              resetReq,
  input  logic              nmiReq,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic [IRQ_W-1:0]  irqLines,
  input  logic              retReq,
  input  logic              ctlWe,
  input  logic              ctlSel,
  input  logic              ieNow,
  input  logic              exlNow,
  input  logic              erlNow,
  input  logic              bootNow,
  input  logic              ivNow,
  output strobe_t           strb,
  output logic [XLEN-1:0]   vecPc
);
  logic [XLEN-1:0] base;
  logic            irqOk;

  always_comb begin
    base  = bootNow ? BOOT_BASE : NORMAL_BASE;
    irqOk = (|irqLines) && ieNow && !exlNow && !erlNow;
    strb  = '0;
    vecPc = RESET_VEC;
    if (resetReq) begin
      strb.enter    = 1'b1;
      strb.errEntry = 1'b1;
      strb.setBoot  = 1'b1;
    end else if (nmiReq) begin
      strb.enter    = 1'b1;
      strb.errEntry = 1'b1;
    end else if (excValid) begin
      strb.enter   = 1'b1;
      strb.code    = excCode;
      strb.takeBad = (excCode >= EC_TLB_MOD) && (excCode <= EC_ADDR_ST);
      strb.takeCop = (excCode == EC_COP_OFF);
      vecPc = (excCode == EC_TLB_LD || excCode == EC_TLB_ST) ?
              base + REFILL_OFF : base + GENERAL_OFF;
    end else if (irqOk) begin
      strb.enter = 1'b1;
      strb.code  = EC_INT;
      vecPc = ivNow ? base + IRQ_OFF : base + GENERAL_OFF;
    end else if (retReq) begin
      strb.leave    = 1'b1;
      strb.leaveErr = erlNow;
    end else if (ctlWe) begin
      strb.wrStatus = !ctlSel;
      strb.wrCause  = ctlSel;
    end
  end
endmodule

// File: rtl/exc_ctl_regs.sv
module exc_ctl_regs
  import exc_ctl_pkg::*;
#(
  parameter int IRQ_W = 6,
  parameter int COP_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [XLEN-1:0]  vecPc,
  input  logic [XLEN-1:0]  excPc,
  input  logic             excInSlot,
  input  logic [XLEN-1:0]  excAddr,
  input  logic [COP_W-1:0] excCop,
  input  logic [IRQ_W-1:0] irqLines,
  input  logic [XLEN-1:0]  ctlWdata,
  output logic [XLEN-1:0]  statusQ,
  output logic [XLEN-1:0]  causeQ,
  output logic [XLEN-1:0]  epcQ,
  output logic [XLEN-1:0]  errPcQ,
  output logic [XLEN-1:0]  badQ,
  output logic             redirectValid,
  output logic [XLEN-1:0]  redirectPc
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ       <= STATUS_RST;
      causeQ        <= '0;
      epcQ          <= '0;
      errPcQ        <= '0;
      badQ          <= '0;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
    end else begin
      causeQ[CA_PEND_LO +: IRQ_W] <= irqLines;
      redirectValid <= strb.enter | strb.leave;
      if (strb.enter) begin
        statusQ[5:0] <= {statusQ[3:0], 2'b00};
        redirectPc   <= vecPc;
        if (strb.errEntry) begin
          errPcQ          <= excPc;
          statusQ[ST_ERL] <= 1'b1;
          if (strb.setBoot) statusQ[ST_BOOT] <= 1'b1;
        end else begin
          epcQ                        <= excInSlot ? excPc - 32'd4 : excPc;
          statusQ[ST_EXL]             <= 1'b1;
          causeQ[CA_CODE_LO +: CODE_W] <= strb.code;
          causeQ[CA_SLOT]             <= excInSlot;
          if (strb.takeBad) badQ <= excAddr;
          if (strb.takeCop) causeQ[CA_COP_LO +: COP_W] <= excCop;
        end
      end else if (strb.leave) begin
        statusQ[5:0] <= {statusQ[5:4], statusQ[5:2]};
        if (strb.leaveErr) begin
          statusQ[ST_ERL] <= 1'b0;
          redirectPc      <= errPcQ;
        end else begin
          statusQ[ST_EXL] <= 1'b0;
          redirectPc      <= epcQ;
        end
      end else if (strb.wrStatus) begin
        statusQ <= ctlWdata & STATUS_MASK;
      end else if (strb.wrCause) begin
        causeQ[CA_IV] <= |(ctlWdata & CAUSE_IV_MASK);
      end
    end
  end
endmodule

// File: rtl/exc_ctl.sv
module exc_ctl
  import exc_ctl_pkg::*;
#(
  parameter int              IRQ_W       = 6,
  parameter int              COP_W       = 2,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] BOOT_BASE   = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] NORMAL_BASE = 32'h8000_0000,
  parameter logic [XLEN-1:0] REFILL_OFF  = 32'h0000_0000,
  parameter logic [XLEN-1:0] GENERAL_OFF = 32'h0000_0180,
  parameter logic [XLEN-1:0] IRQ_OFF     = 32'h0000_0200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetReq,
  input  logic             nmiReq,
  input  logic             excValid,
  input  logic [4:0]       excCode,
  input  logic [31:0]      excPc,
  input  logic             excInSlot,
  input  logic [31:0]      excAddr,
  input  logic [COP_W-1:0] excCop,
  input  logic [IRQ_W-1:0] irqLines,
  input  logic             retReq,
  input  logic             ctlWe,
  input  logic             ctlSel,
  input  logic [31:0]      ctlWdata,
  output logic             redirectValid,
  output logic [31:0]      redirectPc,
  output logic [31:0]      epcOut,
  output logic [31:0]      errPcOut,
  output logic [31:0]      causeOut,
  output logic [31:0]      statusOut,
  output logic [31:0]      badAddrOut
);
  strobe_t         strb;
  logic [XLEN-1:0] vecPc;

  exc_ctl_decide #(
    .IRQ_W(IRQ_W), .RESET_VEC(RESET_VEC), .BOOT_BASE(BOOT_BASE),
    .NORMAL_BASE(NORMAL_BASE), .REFILL_OFF(REFILL_OFF),
    .GENERAL_OFF(GENERAL_OFF), .IRQ_OFF(IRQ_OFF)
  ) uDecide (
    .resetReq(resetReq), .nmiReq(nmiReq), .excValid(excValid),
    .excCode(excCode), .irqLines(irqLines), .retReq(retReq),
    .ctlWe(ctlWe), .ctlSel(ctlSel),
    .ieNow(statusOut[ST_IE]), .exlNow(statusOut[ST_EXL]),
    .erlNow(statusOut[ST_ERL]), .bootNow(statusOut[ST_BOOT]),
    .ivNow(causeOut[CA_IV]),
    .strb(strb), .vecPc(vecPc)
  );

  exc_ctl_regs #(.IRQ_W(IRQ_W), .COP_W(COP_W)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .vecPc(vecPc),
    .excPc(excPc), .excInSlot(excInSlot), .excAddr(excAddr),
    .excCop(excCop), .irqLines(irqLines), .ctlWdata(ctlWdata),
    .statusQ(statusOut), .causeQ(causeOut), .epcQ(epcOut),
    .errPcQ(errPcOut), .badQ(badAddrOut),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );
endmodule

// File: rtl/exc_ctl_chk.sv
module exc_ctl_chk #(
  parameter int IRQ_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             resetReq,
  input logic             nmiReq,
  input logic             excValid,
  input logic [4:0]       excCode,
  input logic [31:0]      excPc,
  input logic             excInSlot,
  input logic [IRQ_W-1:0] irqLines,
  input logic             retReq,
  input logic             redirectValid,
  input logic [31:0]      redirectPc,
  input logic [31:0]      epcOut,
  input logic [31:0]      causeOut,
  input logic [31:0]      statusOut,
  input logic [31:0]      badAddrOut
);
  logic syncWin;
  assign syncWin = excValid && !resetReq && !nmiReq;

  // R2
  entry_kernel_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncWin |=> (statusOut[1:0] == 2'b00 && statusOut[6] && redirectValid));

  // R3
  slot_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncWin && excInSlot) |=> (causeOut[31] && epcOut == $past(excPc) - 32'd4));

  // R4
  bus_err_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncWin && (excCode == 5'd6 || excCode == 5'd7)) |=> $stable(badAddrOut));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!resetReq && !nmiReq && !excValid && !retReq && (|irqLines) && !statusOut[0])
      |=> !redirectValid);

  // R9
  err_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq || nmiReq) |=> (redirectValid && redirectPc == 32'hBFC0_0000 && statusOut[7]));

  // R10
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !resetReq && !nmiReq && !excValid && !(|irqLines))
      |=> (redirectValid && statusOut[1:0] == $past(statusOut[3:2])));
endmodule

bind exc_ctl exc_ctl_chk #(.IRQ_W(IRQ_W)) uChk (.*);

// File: tb/exc_ctl_test.sv
`timescale 1ns/1ps
module exc_ctl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetReq = 0, nmiReq = 0, excValid = 0, excInSlot = 0;
  logic        retReq = 0, ctlWe = 0, ctlSel = 0;
  logic [4:0]  excCode = '0;
  logic [31:0] excPc = '0, excAddr = '0, ctlWdata = '0;
  logic [1:0]  excCop = '0;
  logic [5:0]  irqLines = '0;
  logic        redirectValid;
  logic [31:0] redirectPc, epcOut, errPcOut, causeOut, statusOut, badAddrOut;

  always #2 clk = ~clk;

  exc_ctl uut (.*);

  typedef struct {
    logic [31:0] pc, status, epc, errPc, bad, cause;
    string       tag;
  } exp_t;
  exp_t q[$];

  int errors = 0, checks = 0;
  bit done = 0;
  string curTag = "R1";
  logic [31:0] mStatus = 32'h100, mCause = '0, mEpc = '0, mErr = '0, mBad = '0;
  localparam logic [31:0] PEND_MASK = 32'h0000_FC00;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compare each redirect against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rstN && redirectValid) begin
      if (q.size() == 0) begin
        chk(curTag, "unexpected redirect", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "redirectPc", redirectPc, e.pc);
        chk(e.tag, "status", statusOut, e.status);
        chk(e.tag, "epc", epcOut, e.epc);
        chk(e.tag, "errPc", errPcOut, e.errPc);
        chk(e.tag, "badAddr", badAddrOut, e.bad);
        chk(e.tag, "cause", causeOut & ~PEND_MASK, e.cause);
      end
    end
  end

  task automatic push(logic [31:0] pc, string tag);
    exp_t e;
    e.pc = pc; e.status = mStatus; e.epc = mEpc; e.errPc = mErr;
    e.bad = mBad; e.cause = mCause; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: one cycle of requests, expected result from the requirements
  task automatic drive(bit rst, bit nmi, bit exc, logic [4:0] code, logic [31:0] pc,
                       bit slot, logic [31:0] addr, logic [1:0] cop, logic [5:0] lines,
                       bit ret, bit we, bit sel, logic [31:0] wdata, string tag);
    logic [31:0] base;
    @(negedge clk);
    curTag = tag;
    resetReq = rst; nmiReq = nmi; excValid = exc; excCode = code; excPc = pc;
    excInSlot = slot; excAddr = addr; excCop = cop; irqLines = lines;
    retReq = ret; ctlWe = we; ctlSel = sel; ctlWdata = wdata;
    base = mStatus[8] ? 32'hBFC0_0200 : 32'h8000_0000;
    if (rst || nmi) begin
      mErr = pc; mStatus[5:0] = {mStatus[3:0], 2'b00}; mStatus[7] = 1'b1;
      if (rst) mStatus[8] = 1'b1;
      push(32'hBFC0_0000, tag);
    end else if (exc || ((|lines) && mStatus[0] && !mStatus[6] && !mStatus[7])) begin
      logic [4:0] c;
      c = exc ? code : 5'd0;
      mEpc = slot ? pc - 32'd4 : pc;
      mStatus[5:0] = {mStatus[3:0], 2'b00}; mStatus[6] = 1'b1;
      mCause[6:2] = c; mCause[31] = slot;
      if (c >= 5'd1 && c <= 5'd5) mBad = addr;
      if (c == 5'd11) mCause[29:28] = cop;
      if (!exc) push(mCause[23] ? base + 32'h200 : base + 32'h180, tag);
      else if (c == 5'd2 || c == 5'd3) push(base, tag);
      else push(base + 32'h180, tag);
    end else if (ret) begin
      mStatus[5:0] = {mStatus[5:4], mStatus[5:2]};
      if (mStatus[7]) begin mStatus[7] = 1'b0; push(mErr, tag); end
      else begin mStatus[6] = 1'b0; push(mEpc, tag); end
    end else if (we) begin
      if (!sel) mStatus = wdata & 32'h1FF;
      else mCause[23] = wdata[23];
    end
    @(posedge clk); #1;
    // R8: pending lines follow irqLines one edge later
    chk("R8", "pending", (causeOut >> 10) & 32'h3F, {26'd0, lines});
    if (!redirectValid) begin
      chk(tag, "status (no redirect)", statusOut, mStatus);
      chk(tag, "cause (no redirect)", causeOut & ~PEND_MASK, mCause);
    end
    @(negedge clk);
    resetReq = 0; nmiReq = 0; excValid = 0; retReq = 0; ctlWe = 0; irqLines = '0;
  endtask

  task automatic exc(logic [4:0] code, logic [31:0] pc, bit slot, logic [31:0] addr,
                     logic [1:0] cop, string tag);
    drive(0, 0, 1, code, pc, slot, addr, cop, '0, 0, 0, 0, '0, tag);
  endtask
  task automatic ret(string tag);
    drive(0, 0, 0, '0, 32'h0, 0, 32'h0, 2'd0, '0, 1, 0, 0, '0, tag);
  endtask
  task automatic wr(bit sel, logic [31:0] d, string tag);
    drive(0, 0, 0, '0, 32'h0, 0, 32'h0, 2'd0, '0, 0, 1, sel, d, tag);
  endtask
  task automatic irq(logic [5:0] lines, logic [31:0] pc, string tag);
    drive(0, 0, 0, '0, pc, 0, 32'hFFFF_FFF0, 2'd3, lines, 0, 0, 0, '0, tag);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    chk("R1", "status in reset", statusOut, 32'h100);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "status", statusOut, 32'h100);
    chk("R1", "cause", causeOut, 32'h0);
    chk("R1", "epc", epcOut, 32'h0);
    chk("R1", "errPc", errPcOut, 32'h0);
    chk("R1", "badAddr", badAddrOut, 32'h0);
    chk("R1", "redirectValid", {31'd0, redirectValid}, 32'h0);

    exc(5'd8, 32'h1000, 0, 32'h1234_5678, 2'd1, "R2_R6_boot");     // syscall, boot base
    ret("R10_plain");
    wr(0, 32'hFFFF_0003, "R12_status");                              // user, ie=1, boot=0
    exc(5'd2, 32'h2000, 1, 32'hDEAD_0004, 2'd0, "R3_R4_R6_refill");
    exc(5'd7, 32'h3000, 0, 32'h1111_1111, 2'd2, "R4_buserr");
    exc(5'd6, 32'h3100, 1, 32'h2222_2222, 2'd2, "R4_ibus");
    ret("R10_nest1"); ret("R10_nest2"); ret("R10_nest3");
    exc(5'd11, 32'h4000, 0, 32'h3333_3333, 2'd2, "R5_cop");
    exc(5'd5, 32'h4100, 0, 32'h4444_4444, 2'd1, "R4_R5_keep");
    ret("R10_a"); ret("R10_b");
    wr(0, 32'h0, "R12_mask");
    irq(6'b000101, 32'h5000, "R7_masked_ie0");
    wr(0, 32'h1, "R12_ie");
    wr(1, 32'hFFFF_FFFF, "R12_iv");
    irq(6'b100000, 32'h5100, "R7_taken_iv");
    irq(6'b000001, 32'h5200, "R7_masked_exl");
    ret("R10_irq");
    wr(1, 32'h0, "R12_iv_off");
    irq(6'b010000, 32'h5300, "R7_taken_gen");
    ret("R10_irq2");
    drive(0, 0, 1, 5'd12, 32'h6000, 0, 32'h0, 2'd0, 6'h3F, 0, 0, 0, '0, "R11_exc_over_irq");
    drive(0, 0, 1, 5'd13, 32'h6100, 0, 32'h0, 2'd0, 6'h00, 1, 0, 0, '0, "R11_exc_over_ret");
    ret("R10_c"); ret("R10_d");
    drive(0, 1, 0, 5'd0, 32'h7000, 1, 32'h0, 2'd0, 6'h00, 0, 0, 0, '0, "R9_nmi");
    drive(0, 0, 0, 5'd0, 32'h0, 0, 32'h0, 2'd0, 6'h00, 1, 1, 0, 32'h1FF, "R10_R12_err_ret");
    drive(1, 1, 1, 5'd4, 32'h8000, 0, 32'h5555_5555, 2'd3, 6'h3F, 1, 0, 0, '0, "R9_R11_reset");
    drive(0, 1, 0, 5'd0, 32'h8100, 0, 32'h0, 2'd0, 6'h00, 0, 0, 0, '0, "R9_nmi_nested");
    ret("R10_err1");
    exc(5'd23, 32'h9000, 0, 32'h6666_6666, 2'd0, "R6_boot_watch");
    repeat (3) @(negedge clk);
    chk("R2", "scoreboard drained", q.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule